// File: doc/BRIEF.md
# Board Interrupt and Status Controller

This block gathers sixteen level-sensitive interrupt lines from the board into one interrupt request for the host processor. Each input passes through a two-stage synchronizer. An input that is high while its enable bit is set latches a pending bit. The pending bit stays set until the host rewrites the pending register. The host request line is the OR of every pending bit whose enable bit is also set.

The host reaches the block over a plain 32-bit register bus: byte address, write enable, write data, and combinational read data. Besides the enable and pending registers, the map holds eight general-purpose storage words and two card-slot status words. Input 9 drives an active-low card-present flag in slot word 0. Input 13 drives the same flag in slot word 1. The host can change only the five low control bits of a slot word.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset, both slot words (0xE0, 0xE4) read 0x0000_0420, with bit 10 (ready) and bit 5 (card absent) set. Every other register reads zero, and `irq_o` is low.
- R2: Every input passes through two synchronizer flops. A level presented before rising edge k is first seen by the pending and slot logic on edge k+2, so it becomes visible on the third rising edge.
- R3: A pending bit (register 0xD0, bit n for input n) is set only when synchronized input n is high and enable bit n is set. Once set, it stays set after the input falls. An input whose enable bit is clear sets nothing.
- R4: `irq_o` is a flop. After every clock edge it equals the OR of (pending AND enable), as those registers read after the same edge.
- R5: A write to the enable register at 0xC0 stores the write data ANDed with 0x000F_EEFF.
- R6: A write to the pending register at 0xD0 stores the write data ANDed with 0x000F_EEFF, so a single write can set or clear any implemented bit. If the write and an input-driven set hit the same bit in the same cycle, the bit ends up set.
- R7: Bit 5 of slot word 0 (0xE0) is the inverse of synchronized input 9. Bit 5 of slot word 1 (0xE4) is the inverse of synchronized input 13.
- R8: A write to a slot word loads only bits 4:0. All other bits keep their value.
- R9: The storage words at 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store and return the full 32-bit written value.
- R10: A read from any other address returns zero. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Level-sensitive interrupt inputs from the board |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
A wrong enable or pending bit shows up on `irq_o` right after the edge that stores it, and on a read of 0xC0 or 0xD0 in the same cycle. A bad synchronizer depth moves the pending and card-present response one edge early or late. The bench checks the exact third edge, so that shift is caught. A slot word whose protected bits can be written, or a write decode that reaches an unmapped address, shows at once on the read port. The reference model compares the read data and `irq_o` on every cycle.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int DW       = 32;
  localparam int NUM_IRQ  = 16;
  localparam int NUM_SCR  = 8;
  localparam int HOST_BITS = 5;
  localparam int CD_BIT   = 5;
  localparam int RDY_BIT  = 10;
  localparam int SLOT_IRQ0 = 9;
  localparam int SLOT_IRQ1 = 13;

  localparam logic [DW-1:0] IRQ_MASK = 32'h000F_EEFF;
  localparam logic [DW-1:0] SLOT_RST = (DW'(1) << RDY_BIT) | (DW'(1) << CD_BIT);

  localparam logic [7:0] OFF_EN    = 8'hC0;
  localparam logic [7:0] OFF_PEND  = 8'hD0;
  localparam logic [7:0] OFF_SLOT0 = 8'hE0;
  localparam logic [7:0] OFF_SLOT1 = 8'hE4;

  function automatic logic [7:0] scr_off(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      default: return 8'h90;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= async_i;
      lvl_q  <= meta_q;
    end
  end

  assign sync_o = lvl_q;
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int              NUM_IRQ = 16,
  parameter int              DW      = 32,
  parameter logic [DW-1:0]   MASK    = 32'h000F_EEFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic               en_we_i,
  input  logic               pend_we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      en_o,
  output logic [DW-1:0]      pend_o,
  output logic               irq_o
);
  logic [DW-1:0] en_q, en_d, pend_q, pend_d, lvl_ext, set_vec;
  logic          irq_q, irq_d;

  assign lvl_ext = {{(DW-NUM_IRQ){1'b0}}, lvl_i};
  assign set_vec = lvl_ext & en_q;

  always_comb begin
    en_d   = en_we_i ? (wdata_i & MASK) : en_q;
    // input-driven set overrides a same-cycle host write
    pend_d = (pend_we_i ? (wdata_i & MASK) : pend_q) | set_vec;
    irq_d  = |(pend_d & en_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  p_irq_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_q & en_q));

  p_pend_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_en_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_q == $past(wdata_i & MASK)));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/slot_reg.sv
module slot_reg #(
  parameter int            DW        = 32,
  parameter int            HOST_BITS = 5,
  parameter int            CD_BIT    = 5,
  parameter logic [DW-1:0] RST_VAL   = 32'h0000_0420
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [HOST_BITS-1:0] wdata_i,
  input  logic                 cd_lvl_i,
  output logic [DW-1:0]        slot_o
);
  logic [DW-1:0] slot_q, slot_d;

  always_comb begin
    slot_d         = slot_q;
    slot_d[CD_BIT] = ~cd_lvl_i;  // active-low presence flag
    if (we_i) slot_d[HOST_BITS-1:0] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= RST_VAL;
    else         slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  p_cd_track_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (slot_q[CD_BIT] == !$past(cd_lvl_i)));

  p_host_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (slot_q[HOST_BITS-1:0] == $past(wdata_i)));
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] lvl;
  logic [DW-1:0]      en_val, pend_val;
  logic [DW-1:0]      slot_val [2];
  logic [DW-1:0]      scr_q [NUM_SCR];
  logic               sel_en, sel_pend, hit;

  assign sel_en   = (addr_i == ADDR_W'(OFF_EN));
  assign sel_pend = (addr_i == ADDR_W'(OFF_PEND));

  irq_sync #(.W(NUM_IRQ)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .sync_o  (lvl)
  );

  irq_core #(.NUM_IRQ(NUM_IRQ), .DW(DW), .MASK(IRQ_MASK)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .en_we_i   (we_i && sel_en),
    .pend_we_i (we_i && sel_pend),
    .wdata_i   (wdata_i),
    .en_o      (en_val),
    .pend_o    (pend_val),
    .irq_o     (irq_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int         IDX = (g == 0) ? SLOT_IRQ0 : SLOT_IRQ1;
    localparam logic [7:0] OFF = (g == 0) ? OFF_SLOT0 : OFF_SLOT1;
    slot_reg #(.DW(DW), .HOST_BITS(HOST_BITS), .CD_BIT(CD_BIT), .RST_VAL(SLOT_RST)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (we_i && (addr_i == ADDR_W'(OFF))),
      .wdata_i  (wdata_i[HOST_BITS-1:0]),
      .cd_lvl_i (lvl[IDX]),
      .slot_o   (slot_val[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SCR; i++) scr_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NUM_SCR; i++)
        if (addr_i == ADDR_W'(scr_off(i))) scr_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_SCR; i++) begin
      if (addr_i == ADDR_W'(scr_off(i))) begin
        rdata_o = scr_q[i];
        hit     = 1'b1;
      end
    end
    if (sel_en)                          begin rdata_o = en_val;      hit = 1'b1; end
    if (sel_pend)                        begin rdata_o = pend_val;    hit = 1'b1; end
    if (addr_i == ADDR_W'(OFF_SLOT0))    begin rdata_o = slot_val[0]; hit = 1'b1; end
    if (addr_i == ADDR_W'(OFF_SLOT1))    begin rdata_o = slot_val[1]; hit = 1'b1; end
  end

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));
endmodule

// File: tb/board_irq_ctrl_bench.sv
module board_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] MASK = 32'h000F_EEFF;
  logic [7:0] scr_addr [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

  // behavioural reference state
  logic [15:0] m_s1 = '0, m_s2 = '0;
  logic [31:0] m_en = '0, m_pend = '0;
  logic [31:0] m_scr [8] = '{default: '0};
  logic [31:0] m_slot [2] = '{32'h420, 32'h420};
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  board_irq_ctrl u_board_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_out)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    for (int i = 0; i < 8; i++) if (a == scr_addr[i]) return m_scr[i];
    case (a)
      8'hC0: return m_en;
      8'hD0: return m_pend;
      8'hE0: return m_slot[0];
      8'hE4: return m_slot[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    for (int i = 0; i < 8; i++) if (a == scr_addr[i]) return "R9";
    case (a)
      8'hC0: return "R5";
      8'hD0: return "R6";
      8'hE0, 8'hE4: return "R7";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_en = '0; m_pend = '0; m_irq = 1'b0;
      for (int i = 0; i < 8; i++) m_scr[i] = '0;
      m_slot[0] = 32'h420; m_slot[1] = 32'h420;
    end else begin
      logic [31:0] nen, npend;
      nen = m_en; npend = m_pend;
      if (we) begin
        for (int i = 0; i < 8; i++) if (addr == scr_addr[i]) m_scr[i] = wdata;
        if (addr == 8'hC0) nen = wdata & MASK;
        if (addr == 8'hD0) npend = wdata & MASK;
        if (addr == 8'hE0) m_slot[0][4:0] = wdata[4:0];
        if (addr == 8'hE4) m_slot[1][4:0] = wdata[4:0];
      end
      for (int i = 0; i < 16; i++) if (m_s2[i] && m_en[i]) npend[i] = 1'b1;
      m_slot[0][5] = !m_s2[9];
      m_slot[1][5] = !m_s2[13];
      m_en = nen; m_pend = npend;
      m_irq = |(m_pend & m_en);
      m_s2 = m_s1; m_s1 = irq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk(rst_n ? "R4" : "R1", {31'b0, irq_out}, {31'b0, m_irq});
      chk(rst_n ? tag_of(addr) : "R1", rdata, m_read(addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0;
    #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset values
    rd("R1", 8'hE0, 32'h420);
    rd("R1", 8'hE4, 32'h420);
    rd("R1", 8'hC0, 32'h0);
    rd("R1", 8'hD0, 32'h0);
    rd("R1", 8'h10, 32'h0);
    chk("R1", {31'b0, irq_out}, 32'h0);
    // R9 storage words
    for (int i = 0; i < 8; i++) wr(scr_addr[i], 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 8; i++) rd("R9", scr_addr[i], 32'hA5A5_0000 ^ (32'h1111_1111 * i));
    // R10 unmapped accesses
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h12, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    rd("R10", 8'h20, 32'h0);
    rd("R10", 8'h12, 32'h0);
    rd("R10", 8'h14, 32'hA5A5_0000 ^ 32'h1111_1111);
    rd("R10", 8'hE0, 32'h420);
    // R5 / R6 masks, R4 output
    wr(8'hC0, 32'hFFFF_FFFF);
    rd("R5", 8'hC0, 32'h000F_EEFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    rd("R6", 8'hD0, 32'h000F_EEFF);
    chk("R4", {31'b0, irq_out}, 32'h1);
    wr(8'hD0, 32'h0);
    rd("R6", 8'hD0, 32'h0);
    chk("R4", {31'b0, irq_out}, 32'h0);
    // R2 synchronizer latency, R7 card detect, R3 latch
    irq[9] = 1'b1;
    step(2);
    rd("R2", 8'hE0, 32'h420);
    rd("R2", 8'hD0, 32'h0);
    step(1);
    rd("R7", 8'hE0, 32'h400);
    rd("R3", 8'hD0, 32'h200);
    chk("R4", {31'b0, irq_out}, 32'h1);
    irq[9] = 1'b0;
    step(3);
    rd("R3", 8'hD0, 32'h200);
    rd("R7", 8'hE0, 32'h420);
    // R3 disabled input does not latch
    wr(8'hC0, 32'h0);
    wr(8'hD0, 32'h0);
    irq[3] = 1'b1;
    step(4);
    rd("R3", 8'hD0, 32'h0);
    chk("R3", {31'b0, irq_out}, 32'h0);
    irq[3] = 1'b0;
    // R6 input set wins over same-cycle clear
    wr(8'hC0, 32'h2000);
    irq[13] = 1'b1;
    step(3);
    rd("R6", 8'hD0, 32'h2000);
    rd("R7", 8'hE4, 32'h400);
    wr(8'hD0, 32'h0);
    rd("R6", 8'hD0, 32'h2000);
    irq[13] = 1'b0;
    step(3);
    wr(8'hD0, 32'h0);
    rd("R6", 8'hD0, 32'h0);
    // R8 slot write protection
    wr(8'hE0, 32'hFFFF_FFFF);
    rd("R8", 8'hE0, 32'h43F);
    wr(8'hE4, 32'h0000_0012);
    rd("R8", 8'hE4, 32'h432);
    // random traffic, compared every cycle
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] pick [16] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90,
                                8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h00, 8'h44, 8'hD4, 8'hFC};
      if ($urandom_range(0, 3) == 0) irq = 16'($urandom);
      addr  = pick[$urandom_range(0, 15)];
      we    = ($urandom_range(0, 2) == 0);
      wdata = $urandom;
      step(1);
    end
    we = 1'b0;
    step(2);
    finish_run();
  end
endmodule